// File: doc/BRIEF.md
# Use-Bit Pseudo-LRU Replacement Unit

This block holds the replacement state for a set-associative cache and names the way to evict when the cache needs room. Each set keeps one use bit per way. Any access to a way, whether a hit or a fill, marks that way as recently used. When marking a way would leave the whole set marked, every other mark in that set is cleared, and only the way just touched stays marked.

The surrounding cache reports each access with a set index and a way number, and asks for a victim by giving a set index. The unit answers in the same cycle with a way whose use bit is clear. If more than one way is clear, it picks the lowest-numbered one. Tag lookup, data storage, write policy and miss handling all stay in the cache around this unit.

Top module: `plru_repl_unit`

## Requirements
- R1: After reset every use bit in every set is clear, so a victim request to any set returns way 0.
- R2: An access with `accValid` high sets the use bit of way `accWay` in set `accSet` at the next clock edge.
- R3: If an access would make every use bit of its set equal to 1, the set is left with only the accessed way's bit set.
- R4: The returned victim is always a way whose use bit is 0, and it is the lowest-numbered such way.
- R5: `vicValid` is high in the same cycle as `vicReq` and low when `vicReq` is low. `vicWay` is combinational on `vicSet` and the stored bits.
- R6: An access and a victim request in the same cycle return the victim computed from the state before that access.
- R7: An access changes only the set it names. All other sets keep their bits.
- R8: No set ever holds all use bits set, so a victim always exists.
- R9: While `accValid` is low, the values on `accSet` and `accWay` have no effect on any set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all use bits |
| accValid | input | 1 | An access (hit or fill) happens this cycle |
| accSet | input | $clog2(NUM_SETS) | Set index of the access |
| accWay | input | $clog2(NUM_WAYS) | Way that hit or was filled |
| vicReq | input | 1 | Victim request this cycle |
| vicSet | input | $clog2(NUM_SETS) | Set index of the victim request |
| vicWay | output | $clog2(NUM_WAYS) | Chosen victim way |
| vicValid | output | 1 | Victim output is valid |

## Verification
The assertions check four things on every cycle. First, no set ever holds all ones. Second, an access leaves its way's bit set. Third, sets that were not addressed keep their state. Fourth, a reported victim's bit is clear and `vicValid` follows `vicReq`. Some behaviour can only be shown by the bench's scenarios against its reference model. That covers the exact result of the rollover clear, the lowest-index tie-break, the pre-update answer when an access and a request share a cycle, and the sequences that fill every way back to back, in both the 4-way and the 8-way configurations.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic updEn;     // commit an access to the use bits
    logic lookupEn;  // a victim is being requested
  } plruStrb_t;

endpackage

// File: rtl/plru_ctrl.sv
module plru_ctrl
  import plru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                accValid,
  input  logic [WAY_W-1:0]    accWay,
  input  logic                vicReq,
  output plruStrb_t           strb,
  output logic [NUM_WAYS-1:0] wayMask
);

  always_comb begin
    strb.updEn    = accValid;
    strb.lookupEn = vicReq;
  end

  // One-hot decode of the accessed way
  for (genvar w = 0; w < NUM_WAYS; w++) begin : gWayDec
    assign wayMask[w] = (accWay == WAY_W'(w));
  end

endmodule

// File: rtl/plru_datapath.sv
module plru_datapath
  import plru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  plruStrb_t           strb,
  input  logic [SET_W-1:0]    accSet,
  input  logic [NUM_WAYS-1:0] wayMask,
  input  logic [SET_W-1:0]    vicSet,
  output logic [WAY_W-1:0]    vicWay,
  output logic                vicValid
);

  logic [NUM_WAYS-1:0] useBits [NUM_SETS];
  logic [NUM_WAYS-1:0] curBits, mergedBits, nextBits, reqBits;
  logic                foundClear;

  // Update path: mark the way, fold back to one bit on rollover
  always_comb begin
    curBits    = useBits[accSet];
    mergedBits = curBits | wayMask;
    nextBits   = (&mergedBits) ? wayMask : mergedBits;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : gSet
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        useBits[s] <= '0;
      else if (strb.updEn && (accSet == SET_W'(s)))
        useBits[s] <= nextBits;
    end

    // R7 / R9: sets not addressed by a valid access hold their bits
    a_r7_other_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(strb.updEn && (accSet == SET_W'(s))) |=> $stable(useBits[s]));

    // R8: a set never holds all ones
    a_r8_never_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      useBits[s] != {NUM_WAYS{1'b1}});
  end

  // Victim path: lowest-numbered clear bit of the requested set
  always_comb begin
    reqBits    = useBits[vicSet];
    vicWay     = '0;
    foundClear = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!reqBits[w]) begin
        vicWay     = WAY_W'(w);
        foundClear = 1'b1;
      end
    end
  end

  assign vicValid = strb.lookupEn && foundClear;

  // R2: accessed way is marked after the edge
  a_r2_access_marks_way: assert property (@(posedge clk) disable iff (!rst_n)
    strb.updEn |=> ((useBits[$past(accSet)] & $past(wayMask)) == $past(wayMask)));

  // R4: the reported victim has a clear bit
  a_r4_victim_is_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vicValid |-> !useBits[vicSet][vicWay]);

  // R5: a request is always answered in the same cycle
  a_r5_valid_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    strb.lookupEn |-> vicValid);

  a_r5_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.lookupEn |-> !vicValid);

endmodule

// File: rtl/plru_repl_unit.sv
module plru_repl_unit
  import plru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic             vicReq,
  input  logic [SET_W-1:0] vicSet,
  output logic [WAY_W-1:0] vicWay,
  output logic             vicValid
);

  plruStrb_t           strb;
  logic [NUM_WAYS-1:0] wayMask;

  plru_ctrl #(.NUM_WAYS(NUM_WAYS)) ctrl_i (
    .accValid (accValid),
    .accWay   (accWay),
    .vicReq   (vicReq),
    .strb     (strb),
    .wayMask  (wayMask)
  );

  plru_datapath #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .accSet   (accSet),
    .wayMask  (wayMask),
    .vicSet   (vicSet),
    .vicWay   (vicWay),
    .vicValid (vicValid)
  );

endmodule

// File: tb/plru_repl_unit_tb_top.sv
module plru_repl_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // 4-way, 4-set configuration
  logic       aV4 = 0, vR4 = 0;
  logic [1:0] aS4 = 0, aW4 = 0, vS4 = 0, vW4;
  logic       vV4;
  // 8-way, 2-set configuration
  logic       aV8 = 0, vR8 = 0;
  logic       aS8 = 0, vS8 = 0;
  logic [2:0] aW8 = 0, vW8;
  logic       vV8;

  plru_repl_unit #(.NUM_WAYS(4), .NUM_SETS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .accValid(aV4), .accSet(aS4), .accWay(aW4),
    .vicReq(vR4), .vicSet(vS4), .vicWay(vW4), .vicValid(vV4));

  plru_repl_unit #(.NUM_WAYS(8), .NUM_SETS(2)) dut8_i (
    .clk(clk), .rst_n(rst_n), .accValid(aV8), .accSet(aS8), .accWay(aW8),
    .vicReq(vR8), .vicSet(vS8), .vicWay(vW8), .vicValid(vV8));

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [3:0] ref4 [4];
  logic [7:0] ref8 [2];

  function automatic logic [7:0] refUpd(logic [7:0] b, int w, int n);
    logic [7:0] full = 8'((1 << n) - 1);
    logic [7:0] m = b | 8'(1 << w);
    return (m == full) ? 8'(1 << w) : m;
  endfunction

  function automatic int refVic(logic [7:0] b, int n);
    for (int w = 0; w < n; w++) if (!b[w]) return w;
    return -1;
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, then edge
  task automatic step(bit a4, int s4, int w4, bit r4, int q4,
                      bit a8, int s8, int w8, bit r8, int q8, string req);
    @(negedge clk);
    aV4 = a4; aS4 = 2'(s4); aW4 = 2'(w4); vR4 = r4; vS4 = 2'(q4);
    aV8 = a8; aS8 = 1'(s8); aW8 = 3'(w8); vR8 = r8; vS8 = 1'(q8);
    #1;
    chk({req, " valid4"}, int'(vV4), int'(r4));
    chk({req, " valid8"}, int'(vV8), int'(r8));
    if (r4) chk({req, " victim4"}, int'(vW4), refVic(8'(ref4[q4]), 4));
    if (r8) chk({req, " victim8"}, int'(vW8), refVic(ref8[q8], 8));
    if (a4) ref4[s4] = 4'(refUpd(8'(ref4[s4]), w4, 4));
    if (a8) ref8[s8] = refUpd(ref8[s8], w8, 8);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) ref4[s] = '0;
    for (int s = 0; s < 2; s++) ref8[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, way 0 in every set
    for (int s = 0; s < 4; s++) begin
      step(0, 0, 0, 1, s, 0, 0, 0, 1, s % 2, "R1");
      chk("R1 reset4", int'(vW4), 0);
      chk("R1 reset8", int'(vW8), 0);
    end

    // R5: no request gives no valid
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");

    // R2/R3/R4/R6: back-to-back fill of every way with a same-cycle request
    for (int w = 0; w < 8; w++)
      step(w < 4, 1, w % 4, 1, 1, 1, 1, w, 1, 1, "R6 fill");
    // R3: after the full sweep only the last way stays marked, so victim is 0
    step(0, 0, 0, 1, 1, 0, 0, 0, 1, 1, "R3 rollover");
    chk("R3 after rollover4", int'(vW4), 0);
    chk("R3 after rollover8", int'(vW8), 0);

    // R4: marking way 0 then 1 gives lowest clear way 2
    step(1, 2, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
    step(1, 2, 1, 1, 2, 1, 0, 1, 1, 0, "R2");
    step(0, 0, 0, 1, 2, 0, 0, 0, 1, 0, "R4 tie");
    chk("R4 lowest clear4", int'(vW4), 2);
    chk("R4 lowest clear8", int'(vW8), 2);

    // R9: addresses move while accValid low; state must stay
    for (int k = 0; k < 8; k++)
      step(0, k % 4, k % 4, 1, k % 4, 0, k % 2, k, 1, k % 2, "R9 idle");

    // R7: reverse-order fill of set 3 then check untouched sets
    for (int w = 3; w >= 0; w--)
      step(1, 3, w, 1, 0, 1, 0, w + 4, 1, 1, "R7");

    // Random sweep over both configurations (R2 R3 R4 R6 R7)
    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom);
      step(r[0], (r >> 1) & 3, (r >> 3) & 3, r[5], (r >> 6) & 3,
           r[8], (r >> 9) & 1, (r >> 10) & 7, r[13], (r >> 14) & 1, "R4 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule